// File: doc/BRIEF.md
# Synchronous Rectifier Drive with Soft Start and Isolation Delay

This block produces the two gate-drive waveforms for the synchronous-rectifier switches of an isolated switching converter. A one-tick strobe marks the start of each switching period and restarts an internal tick counter. Each output has a programmed switch-on tick and switch-off tick, both measured within the period. When the switch-off tick is programmed below the switch-on tick, the pulse wraps across the period boundary. This wrapped layout is the one the soft start needs.

With soft start in effect, each output begins at zero on-time after it is enabled. The on-time grows by a fixed step of 8 ticks (40 ns at 5 ns per tick) in each later switching period, and it stops at the programmed on-time. A mode bit chooses whether this ramp runs on every enable or only on the first enable after reset. A kill bit forces the ramp off. A common 6-bit delay then moves both outputs later by 0 to 63 ticks, which offsets the propagation delay of the isolation barrier. The other converter drive signals keep their own timing.

Top module: `sr_softstart_drive`

## Requirements
- R1: While reset is asserted, both outputs are low and the tick counter is zero.
- R2: A strobe on `cyc_start` makes the tick counter read zero in the next clock. Programmed with switch-off < switch-on, an output with no ramp and zero delay is high for (period − switch-on + switch-off) consecutive ticks. Programmed with switch-off ≥ switch-on, it is high for (switch-off − switch-on) ticks.
- R3: With soft start disabled (`ss_enable` = 0), every pulse after an enable has the full programmed width, starting with the first pulse.
- R4: With soft start in effect, the first pulse window after an enable produces no output. The k-th later pulse is min(8·k, L) ticks wide, where L is that window's programmed width.
- R5: The ramped width never exceeds the programmed width of the current window. If the programmed width drops during a ramp, the pulse is clamped to the new width and the ramp ends there.
- R6: With `ss_once` = 0, every new enable restarts the ramp from zero.
- R7: With `ss_once` = 1, the ramp runs only until it has first completed after reset. After that, every enable produces full-width pulses at once.
- R8: The ramp applies only to an output whose switch-off tick is below its switch-on tick; any other output runs at full width. `ss_kill` = 1 disables the ramp on both outputs.
- R9: `sr_delay` = d moves the rising and falling edges of both outputs d ticks later than with d = 0, and leaves the pulse widths unchanged.
- R10: Dropping `drv_en` forces both outputs low in the same clock and clears the ramp accumulators. The next enable, if it ramps, starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock (one tick = 5 ns nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | One-tick strobe at the end of each switching period |
| drv_en | input | 1 | Enable request for both outputs |
| rise_a | input | TW | Switch-on tick of output A |
| fall_a | input | TW | Switch-off tick of output A |
| rise_b | input | TW | Switch-on tick of output B |
| fall_b | input | TW | Switch-off tick of output B |
| ss_enable | input | 1 | Soft start requested |
| ss_once | input | 1 | 1: ramp only until first completion after reset; 0: ramp on every enable |
| ss_kill | input | 1 | Force soft start off |
| sr_delay | input | DW | Common delay in ticks applied to both outputs |
| sr_a | output | 1 | Drive output A |
| sr_b | output | 1 | Drive output B |

## Verification
A ramp accumulator stuck or stepping by the wrong amount shows at the ports as a pulse width that departs from the min(8·k, L) sequence. This appears at the falling edge of the very next pulse, within one switching period. A lost sticky completion flag shows as a second ramp on the second enable in once-only mode. A wrong delay tap shows as a shifted first rising edge right after the enable. A wrongly gated disable shows in the clock in which `drv_en` drops.

// File: rtl/sr_pkg.sv
// Shared definitions for the synchronous-rectifier drive.
// Assumes: two drive channels; configuration bits grouped for internal use.
package sr_pkg;

    localparam int SR_NCH = 2;

    // Soft-start configuration as seen by the control logic.
    typedef struct packed {
        logic enable;   // soft start requested
        logic once;     // ramp only until first completion after reset
        logic kill;     // force soft start off
    } ss_cfg_t;

endpackage

// File: rtl/sr_cycle_counter.sv
// Tick counter inside one switching period.
// Restarts at zero the clock after the period strobe; saturates at its
// maximum if strobes stop arriving. Assumes the strobe is one tick wide.
module sr_cycle_counter #(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_start,
    output logic [TW-1:0] cnt
);

    localparam logic [TW-1:0] CNT_MAX = '1;

    // Count ticks since the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (cyc_start)        cnt <= '0;
        else if (cnt != CNT_MAX)   cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/sr_ramp_channel.sv
// One rectifier drive channel: edge comparison and soft-start ramp.
// The natural window is high from the switch-on tick to the switch-off tick.
// It wraps across the period boundary when switch-off < switch-on. During a
// ramp the output is limited to the first `ramp` ticks of each window. The
// ramp grows by STEP at the end of every complete window and saturates at
// that window's measured length.
// Assumes: en is the raw enable, en_q its registered copy, and start is
// a one-clock pulse issued together with the enable edge.
module sr_ramp_channel #(
    parameter  int TW   = 10,
    parameter  int STEP = 8,
    localparam int RW   = TW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          en_q,
    input  logic          start,
    input  logic [TW-1:0] cnt,
    input  logic [TW-1:0] rise_t,
    input  logic [TW-1:0] fall_t,
    output logic          ss_ok,
    output logic          raw,
    output logic          ramping,
    output logic [RW-1:0] ramp_val
);

    localparam logic [RW:0]   STEP_V  = (RW+1)'(STEP);
    localparam logic [RW-1:0] RUN_MAX = '1;

    logic          win;
    logic          win_q;
    logic          win_begin;
    logic          win_end;
    logic          win_ok;
    logic [RW-1:0] run_q;
    logic [RW-1:0] run_cur;
    logic [RW:0]   ramp_sum;
    logic          gate;

    // Window decode, edge events and ramp gating.
    always_comb begin
        ss_ok     = (fall_t < rise_t);
        if (ss_ok) win = (cnt >= rise_t) || (cnt < fall_t);
        else       win = (cnt >= rise_t) && (cnt < fall_t);
        win_begin = win && !win_q;
        win_end   = win_q && !win;
        run_cur   = win_begin ? '0 : run_q;
        ramp_sum  = {1'b0, ramp_val} + STEP_V;
        gate      = !ramping || (run_cur < ramp_val);
        raw       = win && gate && en_q;
    end

    // Track the window level and the ticks elapsed inside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= 1'b0;
            run_q <= '0;
        end else begin
            win_q <= win;
            if (!win)                   run_q <= '0;
            else if (run_cur != RUN_MAX) run_q <= run_cur + 1'b1;
            else                         run_q <= run_cur;
        end
    end

    // Only windows that began while enabled may advance the ramp.
    always_ff @(posedge clk) begin
        if (!rst_n)                      win_ok <= 1'b0;
        else if (!en)                    win_ok <= 1'b0;
        else if (win_begin && en_q)      win_ok <= 1'b1;
    end

    // Ramp accumulator: clear on disable, launch on start, step per window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ramping  <= 1'b0;
            ramp_val <= '0;
        end else if (!en) begin
            ramping  <= 1'b0;
            ramp_val <= '0;
        end else if (start) begin
            ramping  <= 1'b1;
            ramp_val <= '0;
        end else if (ramping && win_end && win_ok) begin
            if (ramp_sum >= {1'b0, run_q}) begin
                ramp_val <= run_q;
                ramping  <= 1'b0;
            end else begin
                ramp_val <= ramp_sum[RW-1:0];
            end
        end
    end

endmodule

// File: rtl/sr_delay_line.sv
// Programmable tick delay shared by all channels.
// Tap 0 is the input registered once; tap d adds d more ticks. The
// contents are flushed while disabled, and the outputs are gated by the
// raw enable so that a disable takes effect in the same clock.
module sr_delay_line #(
    parameter  int NCH   = 2,
    parameter  int DW    = 6,
    localparam int DEPTH = 1 << DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [DW-1:0]  dly,
    input  logic [NCH-1:0] din,
    output logic [NCH-1:0] dout
);

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        logic [DEPTH-1:0] sh;

        // Shift the channel's raw drive along the tap chain.
        always_ff @(posedge clk) begin
            if (!rst_n)   sh <= '0;
            else if (!en) sh <= '0;
            else          sh <= {sh[DEPTH-2:0], din[c]};
        end

        // Select the programmed tap and gate it with the enable.
        always_comb dout[c] = en && sh[dly];
    end

endmodule

// File: rtl/sr_softstart_drive.sv
// Top level: two synchronous-rectifier drive outputs with soft start and
// a common isolation delay. It decides at each enable edge which channels
// ramp, keeps the sticky first-ramp-done flag for once-only mode, and
// routes the channel drives through the delay line.
// Assumes: configuration and edge ticks change only while drv_en is low,
// except that edge ticks may change between windows.
module sr_softstart_drive #(
    parameter int TW   = 10,
    parameter int DW   = 6,
    parameter int STEP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_start,
    input  logic          drv_en,
    input  logic [TW-1:0] rise_a,
    input  logic [TW-1:0] fall_a,
    input  logic [TW-1:0] rise_b,
    input  logic [TW-1:0] fall_b,
    input  logic          ss_enable,
    input  logic          ss_once,
    input  logic          ss_kill,
    input  logic [DW-1:0] sr_delay,
    output logic          sr_a,
    output logic          sr_b
);

    import sr_pkg::*;

    localparam int NCH = SR_NCH;
    localparam int RW  = TW + 1;

    ss_cfg_t          cfg;
    logic [TW-1:0]    cnt;
    logic [TW-1:0]    rise_arr [NCH];
    logic [TW-1:0]    fall_arr [NCH];
    logic [NCH-1:0]   ss_ok_vec;
    logic [NCH-1:0]   raw_vec;
    logic [NCH-1:0]   ramping_vec;
    logic [NCH-1:0]   launch_vec;
    logic [RW-1:0]    ramp_arr [NCH];
    logic [NCH-1:0]   drive_vec;
    logic             en_q;
    logic             en_rise;
    logic             ramp_allowed;
    logic             launched;
    logic             first_done;

    // Gather configuration and per-channel edge settings.
    always_comb begin
        cfg         = '{enable: ss_enable, once: ss_once, kill: ss_kill};
        rise_arr[0] = rise_a;
        fall_arr[0] = fall_a;
        rise_arr[1] = rise_b;
        fall_arr[1] = fall_b;
    end

    // Decide at the enable edge which channels start a ramp.
    always_comb begin
        en_rise      = drv_en && !en_q;
        ramp_allowed = cfg.enable && !cfg.kill && !(cfg.once && first_done);
        for (int c = 0; c < NCH; c++)
            launch_vec[c] = en_rise && ramp_allowed && ss_ok_vec[c];
    end

    // Registered enable used to qualify the drive.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= drv_en;
    end

    // Remember that a ramp was launched in this enable session.
    always_ff @(posedge clk) begin
        if (!rst_n)            launched <= 1'b0;
        else if (!drv_en)      launched <= 1'b0;
        else if (|launch_vec)  launched <= 1'b1;
    end

    // Sticky flag: the first ramp after reset has completed.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      first_done <= 1'b0;
        else if (launched && en_q && !(|ramping_vec))    first_done <= 1'b1;
    end

    sr_cycle_counter #(.TW(TW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .cnt       (cnt)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sr_ramp_channel #(.TW(TW), .STEP(STEP)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (drv_en),
            .en_q     (en_q),
            .start    (launch_vec[c]),
            .cnt      (cnt),
            .rise_t   (rise_arr[c]),
            .fall_t   (fall_arr[c]),
            .ss_ok    (ss_ok_vec[c]),
            .raw      (raw_vec[c]),
            .ramping  (ramping_vec[c]),
            .ramp_val (ramp_arr[c])
        );
    end

    sr_delay_line #(.NCH(NCH), .DW(DW)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (drv_en),
        .dly   (sr_delay),
        .din   (raw_vec),
        .dout  (drive_vec)
    );

    // Drive outputs.
    always_comb begin
        sr_a = drive_vec[0];
        sr_b = drive_vec[1];
    end

endmodule

// File: rtl/sr_softstart_checker.sv
// Property checker for sr_softstart_drive, attached by bind below.
module sr_softstart_checker #(
    parameter int TW   = 10,
    parameter int DW   = 6,
    parameter int STEP = 8,
    parameter int RW   = TW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cyc_start,
    input logic          drv_en,
    input logic [DW-1:0] sr_delay,
    input logic [TW-1:0] cnt,
    input logic          sr_a,
    input logic          sr_b,
    input logic          raw_a,
    input logic [RW-1:0] ramp_a,
    input logic [RW-1:0] ramp_b,
    input logic          ramping_a,
    input logic          first_done
);

    localparam logic [RW-1:0] STEP_V = RW'(STEP);

    assert_cnt_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> (cnt == '0));

    assert_off_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |-> (!sr_a && !sr_b));

    assert_ramp_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |=> (ramp_a == '0 && ramp_b == '0));

    assert_ramp_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ramping_a && ramp_a != $past(ramp_a)) |-> (ramp_a == $past(ramp_a) + STEP_V || ramp_a == '0));

    assert_once_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(first_done) |-> first_done);

    assert_zero_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_delay == '0 && drv_en && $past(drv_en)) |-> (sr_a == $past(raw_a)));

endmodule

bind sr_softstart_drive sr_softstart_checker #(.TW(TW), .DW(DW), .STEP(STEP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .drv_en     (drv_en),
    .sr_delay   (sr_delay),
    .cnt        (cnt),
    .sr_a       (sr_a),
    .sr_b       (sr_b),
    .raw_a      (raw_vec[0]),
    .ramp_a     (ramp_arr[0]),
    .ramp_b     (ramp_arr[1]),
    .ramping_a  (ramping_vec[0]),
    .first_done (first_done)
);

// File: tb/sr_softstart_drive_test.sv
// Scoreboard bench: driver tasks queue expected pulse widths per output,
// a monitor measures each finished pulse and compares.
module sr_softstart_drive_test;

    localparam int TW = 10;
    localparam int DW = 6;
    localparam int P  = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_start = 1'b0;
    logic          drv_en = 1'b0;
    logic [TW-1:0] rise_a = 10'd60;
    logic [TW-1:0] fall_a = 10'd20;
    logic [TW-1:0] rise_b = 10'd70;
    logic [TW-1:0] fall_b = 10'd10;
    logic          ss_enable = 1'b0;
    logic          ss_once = 1'b0;
    logic          ss_kill = 1'b0;
    logic [DW-1:0] sr_delay = '0;
    logic          sr_a;
    logic          sr_b;

    sr_softstart_drive #(.TW(TW), .DW(DW), .STEP(8)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .drv_en(drv_en),
        .rise_a(rise_a), .fall_a(fall_a), .rise_b(rise_b), .fall_b(fall_b),
        .ss_enable(ss_enable), .ss_once(ss_once), .ss_kill(ss_kill),
        .sr_delay(sr_delay), .sr_a(sr_a), .sr_b(sr_b)
    );

    always #4 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    int ph = 0;
    int tick = 0;
    bit mon_on = 1'b1;
    bit done = 1'b0;
    int q_a[$];
    int q_b[$];
    string tg_a[$];
    string tg_b[$];
    int run_len[2];
    bit prev[2];
    bit arm[2];
    int t_rise[2];
    int t_en = 0;

    // Stimulus timeline: phase within the switching period and tick count.
    always @(posedge clk) begin
        tick <= tick + 1;
        if (!rst_n || cyc_start) ph <= 0;
        else                     ph <= ph + 1;
    end

    always @(negedge clk) cyc_start <= rst_n && (ph == P - 1);

    task automatic chk(bit ok, string tag, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(int ch, int v, string tag);
        if (ch == 0) begin q_a.push_back(v); tg_a.push_back(tag); end
        else         begin q_b.push_back(v); tg_b.push_back(tag); end
    endtask

    // Queue n pulses: full width, or the ramp sequence min(8k, len).
    task automatic expect_pulses(int ch, int len, int n, bit ramp, string tag);
        for (int k = 1; k <= n; k++)
            push(ch, ramp ? ((8 * k < len) ? 8 * k : len) : len, tag);
    endtask

    // Monitor: measure each pulse and compare against the queue.
    always @(negedge clk) begin
        #1;
        for (int ch = 0; ch < 2; ch++) begin
            bit cur;
            cur = (ch == 0) ? sr_a : sr_b;
            if (cur) begin
                if (!prev[ch]) begin
                    run_len[ch] = 0;
                    if (arm[ch]) begin t_rise[ch] = tick; arm[ch] = 1'b0; end
                end
                run_len[ch]++;
            end else if (prev[ch] && mon_on) begin
                if (ch == 0) begin
                    if (q_a.size() == 0) chk(1'b0, "unexpected pulse on A", run_len[ch], 0);
                    else begin
                        int e; string t;
                        e = q_a.pop_front(); t = tg_a.pop_front();
                        chk(run_len[ch] == e, t, run_len[ch], e);
                    end
                end else begin
                    if (q_b.size() == 0) chk(1'b0, "unexpected pulse on B", run_len[ch], 0);
                    else begin
                        int e; string t;
                        e = q_b.pop_front(); t = tg_b.pop_front();
                        chk(run_len[ch] == e, t, run_len[ch], e);
                    end
                end
            end
            prev[ch] = cur;
        end
    end

    task automatic wait_ph(int x);
        do @(negedge clk); while (ph != x);
    endtask

    task automatic drain(string tag);
        repeat (20) @(negedge clk);
        #2;
        chk(q_a.size() == 0, tag, q_a.size(), 0);
        chk(q_b.size() == 0, tag, q_b.size(), 0);
    endtask

    // Enable at phase en_ph, run nper periods, disable at phase off_ph.
    task automatic session(int en_ph, int nper, int off_ph, string tag);
        wait_ph(en_ph);
        drv_en = 1'b1;
        t_en = tick;
        repeat (nper) wait_ph(en_ph);
        if (off_ph != en_ph) wait_ph(off_ph);
        drv_en = 1'b0;
        drain(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        chk(sr_a == 1'b0 && sr_b == 1'b0, "R1 outputs low in reset", {sr_a, sr_b}, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int d0a, d0b;
        do_reset();

        // R2 R3: no soft start, full widths (A wraps: 60, B wraps: 40)
        expect_pulses(0, 60, 3, 1'b0, "R3 full width A");
        expect_pulses(1, 40, 3, 1'b0, "R2 full width B");
        session(30, 3, 30, "R3 queue empty");

        // R4 R5: ramp every enable
        ss_enable = 1'b1;
        expect_pulses(0, 60, 9, 1'b1, "R4 ramp A");
        expect_pulses(1, 40, 9, 1'b1, "R5 ramp saturates B");
        session(30, 10, 30, "R4 queue empty");

        // R6: re-enable restarts from zero
        expect_pulses(0, 60, 3, 1'b1, "R6 restart A");
        expect_pulses(1, 40, 3, 1'b1, "R6 restart B");
        session(30, 4, 30, "R6 queue empty");

        // R5: target drops to 30 mid-ramp
        push(0, 8, "R5 clamp A"); push(0, 16, "R5 clamp A"); push(0, 24, "R5 clamp A");
        push(0, 30, "R5 clamp A"); push(0, 30, "R5 clamp A");
        expect_pulses(1, 40, 5, 1'b1, "R5 B unaffected");
        wait_ph(30);
        drv_en = 1'b1;
        repeat (4) wait_ph(30);
        rise_a = 10'd90;
        repeat (2) wait_ph(30);
        drv_en = 1'b0;
        drain("R5 queue empty");
        rise_a = 10'd60;

        // R10: disable mid-pulse, then ramp starts again from zero
        expect_pulses(0, 60, 3, 1'b1, "R10 pre A");
        expect_pulses(1, 40, 3, 1'b1, "R10 pre B");
        wait_ph(30);
        drv_en = 1'b1;
        repeat (4) wait_ph(30);
        wait_ph(70);
        #2;
        chk(sr_a == 1'b1, "R4 pulse active before disable", sr_a, 1);
        mon_on = 1'b0;
        drv_en = 1'b0;
        #1;
        chk(sr_a == 1'b0 && sr_b == 1'b0, "R10 immediate low", {sr_a, sr_b}, 0);
        drain("R10 queue empty");
        mon_on = 1'b1;
        expect_pulses(0, 60, 2, 1'b1, "R10 ramp from zero A");
        expect_pulses(1, 40, 2, 1'b1, "R10 ramp from zero B");
        session(30, 3, 30, "R10 queue empty after");

        // R8: kill bit gives full width
        ss_kill = 1'b1;
        expect_pulses(0, 60, 3, 1'b0, "R8 kill A");
        expect_pulses(1, 40, 3, 1'b0, "R8 kill B");
        session(30, 3, 30, "R8 kill queue empty");
        ss_kill = 1'b0;

        // R8: non-wrapped A (20..70) runs full, wrapped B still ramps
        rise_a = 10'd20; fall_a = 10'd70;
        expect_pulses(0, 50, 3, 1'b0, "R8 ordering A full");
        expect_pulses(1, 40, 2, 1'b1, "R8 ordering B ramps");
        session(15, 3, 15, "R8 ordering queue empty");
        rise_a = 10'd60; fall_a = 10'd20;

        // R9: delay 0, 5, 63 ticks
        ss_enable = 1'b0;
        sr_delay = 6'd0;
        arm[0] = 1'b1; arm[1] = 1'b1;
        expect_pulses(0, 60, 2, 1'b0, "R9 width A d0");
        expect_pulses(1, 40, 2, 1'b0, "R9 width B d0");
        session(30, 2, 30, "R9 d0 queue empty");
        d0a = t_rise[0] - t_en;
        d0b = t_rise[1] - t_en;
        sr_delay = 6'd5;
        arm[0] = 1'b1; arm[1] = 1'b1;
        expect_pulses(0, 60, 2, 1'b0, "R9 width A d5");
        expect_pulses(1, 40, 2, 1'b0, "R9 width B d5");
        session(30, 2, 30, "R9 d5 queue empty");
        chk(t_rise[0] - t_en - d0a == 5, "R9 shift A d5", t_rise[0] - t_en - d0a, 5);
        chk(t_rise[1] - t_en - d0b == 5, "R9 shift B d5", t_rise[1] - t_en - d0b, 5);
        sr_delay = 6'd63;
        arm[0] = 1'b1; arm[1] = 1'b1;
        expect_pulses(0, 60, 2, 1'b0, "R9 width A d63");
        expect_pulses(1, 40, 2, 1'b0, "R9 width B d63");
        session(30, 2, 90, "R9 d63 queue empty");
        chk(t_rise[0] - t_en - d0a == 63, "R9 shift A d63", t_rise[0] - t_en - d0a, 63);
        chk(t_rise[1] - t_en - d0b == 63, "R9 shift B d63", t_rise[1] - t_en - d0b, 63);
        sr_delay = 6'd0;

        // R7: once-only mode after a fresh reset
        ss_enable = 1'b1;
        ss_once = 1'b1;
        do_reset();
        expect_pulses(0, 60, 9, 1'b1, "R7 first ramp A");
        expect_pulses(1, 40, 9, 1'b1, "R7 first ramp B");
        session(30, 10, 30, "R7 first queue empty");
        expect_pulses(0, 60, 3, 1'b0, "R7 no second ramp A");
        expect_pulses(1, 40, 3, 1'b0, "R7 no second ramp B");
        session(30, 3, 30, "R7 second queue empty");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule